// File: doc/BRIEF.md
# Domain Memory Permission Checker

This block decides, for every physically addressed access made while a hart runs inside a supervisor domain, whether the access may go ahead. It looks up a small local permission table. The table is indexed by the active domain identifier together with the 4 KiB physical page number of the access. The block then combines that answer with the verdicts already reached by the page-table and PMP stages. An access is granted only when all three agree. Otherwise the block raises an access fault whose cause matches the kind of the original access. The physical address is never translated: it leaves the block exactly as it came in, and only permission bits are consulted.

Machine-mode software sets the active domain identifier, the table mode (Bare or checked) and the page number where the table's own storage lives. It also fills the table entries through a write port that ignores requests made at lower privilege. Implicit accesses get their own handling. Page-table walk reads are checked as reads, and accessed/dirty updates are checked as writes. Accesses that land on the table's own storage skip the table check. A denied access never returns data.

Top module: `dom_perm_chk`

## Requirements
- R1: Each table entry holds two bits: bit 0 grants read and bit 1 grants write. A load (`req_kind`=1) or an instruction fetch (`req_kind`=0) needs bit 0. A store (`req_kind`=2) needs bit 1.
- R2: An access is granted only when `req_pt_ok`, `req_pmp_ok` and the table check all allow it. Any single denial produces a fault.
- R3: A page-table walk read (`req_implicit`=1) is checked as a read, and an accessed/dirty update (`req_implicit`=2) is checked as a write, whatever `req_kind` is. The fault cause still follows `req_kind`.
- R4: An access whose page number lies in the window of `ROOT_PAGES` pages starting at the stored root page passes the table check regardless of entry contents.
- R5: The fault cause is 1 for a fetch, 5 for a load and 7 for a store. `chk_cause` is 0 whenever no fault is reported.
- R6: `chk_rdata` carries the `req_rdata` captured with the request when the access is granted, and is zero whenever a fault is reported.
- R7: In Bare mode (mode bit 0) the table check always permits. The page-table and PMP verdicts still apply.
- R8: Configuration writes (`cfg_sel` 0 = domain id, 1 = mode from bit 0, 2 = root page) and table writes take effect only when `m_priv`=3. At any other privilege they leave all state unchanged.
- R9: `chk_pa` equals the `req_pa` of the request it reports, bit for bit.
- R10: The verdict appears one clock after the request edge as a single-cycle `chk_valid` pulse, with exactly one of `chk_grant` and `chk_fault` high. Both are low when `chk_valid` is low.
- R11: A page number at or above 2^`PAGE_IDX_W` has no permissions, so it faults in checked mode unless R4 exempts it.
- R12: Entries are kept separately for each domain identifier. The active identifier selects which set an access is checked against.
- R13: After reset the domain identifier is 0, the mode is Bare, all table entries are zero and no verdict is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_pa | input | PA_W | Physical address of the access |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_implicit | input | 2 | 0 explicit, 1 walk read, 2 accessed/dirty update |
| req_pt_ok | input | 1 | Page-table stage permits |
| req_pmp_ok | input | 1 | PMP stage permits |
| req_rdata | input | DATA_W | Read data accompanying the request |
| m_priv | input | 2 | Privilege of configuration/table writer (3 = machine) |
| cfg_we | input | 1 | Configuration register write |
| cfg_sel | input | 2 | Register select: 0 domain id, 1 mode, 2 root page |
| cfg_wdata | input | PA_W-PAGE_SHIFT | Configuration write data |
| tbl_we | input | 1 | Table entry write |
| tbl_sdid | input | SDID_W | Domain of the entry written |
| tbl_page | input | PAGE_IDX_W | Page index of the entry written |
| tbl_perm | input | 2 | Entry value (bit 0 read, bit 1 write) |
| chk_valid | output | 1 | Verdict pulse |
| chk_grant | output | 1 | Access granted |
| chk_fault | output | 1 | Access faulted |
| chk_cause | output | 4 | Fault cause code |
| chk_pa | output | PA_W | Untranslated physical address |
| chk_rdata | output | DATA_W | Gated read data |
| cur_sdid | output | SDID_W | Active domain identifier |
| cur_mode | output | 1 | Active mode (0 Bare, 1 checked) |

## Verification
Every verdict, the passed-through address and the gated read data are due one clock after the edge that samples the request. The bench drives a request on a falling edge, lets one rising edge pass, and reads all of them at the next falling edge. It then lowers `req_valid` and confirms one falling edge later that the pulse has ended. Configuration and table writes land on the rising edge after they are driven, so the bench issues them as separate single-cycle operations before any request that depends on them. It reads `cur_sdid` and `cur_mode` only after that edge.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  localparam logic [1:0] IMP_NONE = 2'd0;
  localparam logic [1:0] IMP_WALK = 2'd1;
  localparam logic [1:0] IMP_AD   = 2'd2;

  localparam logic [1:0] PRIV_MACHINE = 2'd3;

  localparam logic [1:0] SEL_SDID = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_ROOT = 2'd2;

  localparam logic [3:0] CAUSE_NONE  = 4'd0;
  localparam logic [3:0] CAUSE_FETCH = 4'd1;
  localparam logic [3:0] CAUSE_LOAD  = 4'd5;
  localparam logic [3:0] CAUSE_STORE = 4'd7;

  // Permission an access needs: implicit kind overrides the original kind
  function automatic logic needs_write(input logic [1:0] kind, input logic [1:0] imp);
    if (imp == IMP_AD)        return 1'b1;
    else if (imp == IMP_WALK) return 1'b0;
    else                      return (kind == KIND_STORE);
  endfunction

  function automatic logic perm_allows(input logic [1:0] perm, input logic wr);
    return wr ? perm[1] : perm[0];
  endfunction

  function automatic logic [3:0] fault_cause(input logic [1:0] kind);
    case (kind)
      KIND_FETCH: return CAUSE_FETCH;
      KIND_STORE: return CAUSE_STORE;
      default:    return CAUSE_LOAD;
    endcase
  endfunction

endpackage

// File: rtl/dpc_cfg.sv
module dpc_cfg
  import dpc_pkg::*;
#(
  parameter int SDID_W = 2,
  parameter int CFG_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        m_priv,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [SDID_W-1:0] sdid,
  output logic              mode_on,
  output logic [CFG_W-1:0]  root_ppn
);

  logic wr_ok;
  assign wr_ok = cfg_we && (m_priv == PRIV_MACHINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdid     <= '0;
      mode_on  <= 1'b0;
      root_ppn <= '0;
    end else if (wr_ok) begin
      case (cfg_sel)
        SEL_SDID: sdid     <= cfg_wdata[SDID_W-1:0];
        SEL_MODE: mode_on  <= cfg_wdata[0];
        SEL_ROOT: root_ppn <= cfg_wdata;
        default:  ;
      endcase
    end
  end

  // R8
  low_priv_cfg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && m_priv != PRIV_MACHINE) |=> ($stable(sdid) && $stable(mode_on) && $stable(root_ppn)));

endmodule

// File: rtl/dpc_table.sv
module dpc_table
  import dpc_pkg::*;
#(
  parameter int SDID_W     = 2,
  parameter int PAGE_IDX_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            m_priv,
  input  logic                  wr_en,
  input  logic [SDID_W-1:0]     wr_sdid,
  input  logic [PAGE_IDX_W-1:0] wr_page,
  input  logic [1:0]            wr_perm,
  input  logic                  rd_en,
  input  logic                  rd_in_range,
  input  logic [SDID_W-1:0]     rd_sdid,
  input  logic [PAGE_IDX_W-1:0] rd_page,
  output logic [1:0]            perm_q
);

  localparam int IDX_W   = SDID_W + PAGE_IDX_W;
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0] mem [ENTRIES];
  logic       wr_ok;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign wr_ok  = wr_en && (m_priv == PRIV_MACHINE);
  assign wr_idx = {wr_sdid, wr_page};
  assign rd_idx = {rd_sdid, rd_page};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[wr_idx] <= wr_perm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     perm_q <= '0;
    else if (rd_en) perm_q <= rd_in_range ? mem[rd_idx] : 2'b00;
  end

  // R11
  oor_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_in_range) |=> (perm_q == 2'b00));

endmodule

// File: rtl/dpc_verdict.sv
module dpc_verdict
  import dpc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              v,
  input  logic [1:0]        kind,
  input  logic [1:0]        imp,
  input  logic              pt_ok,
  input  logic              pmp_ok,
  input  logic [1:0]        perm,
  input  logic              bare,
  input  logic              exempt,
  input  logic [DATA_W-1:0] rdata_in,
  output logic              tbl_allow,
  output logic              grant,
  output logic              fault,
  output logic [3:0]        cause,
  output logic [DATA_W-1:0] rdata_out
);

  logic wr_need;
  logic all_ok;

  assign wr_need   = needs_write(kind, imp);
  assign tbl_allow = bare || exempt || perm_allows(perm, wr_need);
  assign all_ok    = pt_ok && pmp_ok && tbl_allow;
  assign grant     = v && all_ok;
  assign fault     = v && !all_ok;
  assign cause     = fault ? fault_cause(kind) : CAUSE_NONE;
  assign rdata_out = grant ? rdata_in : '0;

  // R6
  always_comb begin
    fault_no_data_chk: assert (!fault || rdata_out == '0);
  end

endmodule

// File: rtl/dom_perm_chk.sv
module dom_perm_chk
  import dpc_pkg::*;
#(
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SDID_W     = 2,
  parameter int PAGE_IDX_W = 6,
  parameter int DATA_W     = 32,
  parameter int ROOT_PAGES = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [PA_W-1:0]            req_pa,
  input  logic [1:0]                 req_kind,
  input  logic [1:0]                 req_implicit,
  input  logic                       req_pt_ok,
  input  logic                       req_pmp_ok,
  input  logic [DATA_W-1:0]          req_rdata,
  input  logic [1:0]                 m_priv,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [PA_W-PAGE_SHIFT-1:0] cfg_wdata,
  input  logic                       tbl_we,
  input  logic [SDID_W-1:0]          tbl_sdid,
  input  logic [PAGE_IDX_W-1:0]      tbl_page,
  input  logic [1:0]                 tbl_perm,
  output logic                       chk_valid,
  output logic                       chk_grant,
  output logic                       chk_fault,
  output logic [3:0]                 chk_cause,
  output logic [PA_W-1:0]            chk_pa,
  output logic [DATA_W-1:0]          chk_rdata,
  output logic [SDID_W-1:0]          cur_sdid,
  output logic                       cur_mode
);

  localparam int PPN_W = PA_W - PAGE_SHIFT;

  logic [SDID_W-1:0] sdid;
  logic              mode_on;
  logic [PPN_W-1:0]  root_ppn;

  dpc_cfg #(.SDID_W(SDID_W), .CFG_W(PPN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .m_priv(m_priv),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .sdid(sdid), .mode_on(mode_on), .root_ppn(root_ppn)
  );

  // Request-side page decode
  logic [PPN_W-1:0] req_ppn;
  logic [PPN_W-1:0] root_off;
  logic             ppn_in_range;
  logic             ppn_exempt;

  assign req_ppn  = req_pa[PA_W-1:PAGE_SHIFT];
  assign root_off = req_ppn - root_ppn;

  generate
    if (PPN_W > PAGE_IDX_W) begin : g_range
      assign ppn_in_range = (req_ppn[PPN_W-1:PAGE_IDX_W] == '0);
    end else begin : g_full
      assign ppn_in_range = 1'b1;
    end
  endgenerate

  assign ppn_exempt = (req_ppn >= root_ppn) && (root_off < PPN_W'(ROOT_PAGES));

  logic [1:0] perm_q;

  dpc_table #(.SDID_W(SDID_W), .PAGE_IDX_W(PAGE_IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .m_priv(m_priv),
    .wr_en(tbl_we), .wr_sdid(tbl_sdid), .wr_page(tbl_page), .wr_perm(tbl_perm),
    .rd_en(req_valid), .rd_in_range(ppn_in_range),
    .rd_sdid(sdid), .rd_page(req_ppn[PAGE_IDX_W-1:0]),
    .perm_q(perm_q)
  );

  // Request stage registers
  logic              v_q;
  logic [1:0]        kind_q, imp_q;
  logic              pt_q, pmp_q, bare_q, exempt_q;
  logic [PA_W-1:0]   pa_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= KIND_FETCH;
      imp_q    <= IMP_NONE;
      pt_q     <= 1'b0;
      pmp_q    <= 1'b0;
      bare_q   <= 1'b1;
      exempt_q <= 1'b0;
      pa_q     <= '0;
      rdata_q  <= '0;
    end else if (req_valid) begin
      kind_q   <= req_kind;
      imp_q    <= req_implicit;
      pt_q     <= req_pt_ok;
      pmp_q    <= req_pmp_ok;
      bare_q   <= !mode_on;
      exempt_q <= ppn_exempt;
      pa_q     <= req_pa;
      rdata_q  <= req_rdata;
    end
  end

  logic tbl_allow;

  dpc_verdict #(.DATA_W(DATA_W)) u_verdict (
    .v(v_q), .kind(kind_q), .imp(imp_q), .pt_ok(pt_q), .pmp_ok(pmp_q),
    .perm(perm_q), .bare(bare_q), .exempt(exempt_q), .rdata_in(rdata_q),
    .tbl_allow(tbl_allow), .grant(chk_grant), .fault(chk_fault),
    .cause(chk_cause), .rdata_out(chk_rdata)
  );

  assign chk_valid = v_q;
  assign chk_pa    = pa_q;
  assign cur_sdid  = sdid;
  assign cur_mode  = mode_on;

  // R10
  verdict_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> chk_valid);

  // R10
  no_stray_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !chk_valid);

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $onehot({chk_grant, chk_fault}));

  // R10
  quiet_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |-> !(chk_grant || chk_fault));

  // R2
  upstream_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_pt_ok && req_pmp_ok)) |=> chk_fault);

  // R7
  bare_table_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode_on) |=> tbl_allow);

  // R9
  pa_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (chk_pa == $past(req_pa)));

  // R5
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_fault |-> (chk_cause == 4'd0));

endmodule

// File: tb/test_dom_perm_chk.sv
module test_dom_perm_chk;

  localparam int PA_W = 32;
  localparam int DW   = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_pa = '0;
  logic [1:0]  req_kind = '0, req_implicit = '0;
  logic        req_pt_ok = 1'b0, req_pmp_ok = 1'b0;
  logic [31:0] req_rdata = '0;
  logic [1:0]  m_priv = 2'd3;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [19:0] cfg_wdata = '0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_sdid = '0;
  logic [5:0]  tbl_page = '0;
  logic [1:0]  tbl_perm = '0;
  logic        chk_valid, chk_grant, chk_fault;
  logic [3:0]  chk_cause;
  logic [31:0] chk_pa, chk_rdata;
  logic [1:0]  cur_sdid;
  logic        cur_mode;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  dom_perm_chk i_dom_perm_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pa(req_pa),
    .req_kind(req_kind), .req_implicit(req_implicit), .req_pt_ok(req_pt_ok),
    .req_pmp_ok(req_pmp_ok), .req_rdata(req_rdata), .m_priv(m_priv),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tbl_we(tbl_we), .tbl_sdid(tbl_sdid), .tbl_page(tbl_page), .tbl_perm(tbl_perm),
    .chk_valid(chk_valid), .chk_grant(chk_grant), .chk_fault(chk_fault),
    .chk_cause(chk_cause), .chk_pa(chk_pa), .chk_rdata(chk_rdata),
    .cur_sdid(cur_sdid), .cur_mode(cur_mode)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [19:0] data, input logic [1:0] priv);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data; m_priv = priv;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0; m_priv = 2'd3;
  endtask

  task automatic tbl_write(input logic [1:0] sd, input logic [5:0] pg, input logic [1:0] perm,
                           input logic [1:0] priv);
    tbl_we = 1'b1; tbl_sdid = sd; tbl_page = pg; tbl_perm = perm; m_priv = priv;
    @(posedge clk); @(negedge clk);
    tbl_we = 1'b0; m_priv = 2'd3;
  endtask

  // Drive at a falling edge; results are read at the next falling edge
  task automatic issue(input logic [31:0] pa, input logic [1:0] kind, input logic [1:0] imp,
                       input logic pt, input logic pmp, input logic [31:0] rd);
    req_valid = 1'b1; req_pa = pa; req_kind = kind; req_implicit = imp;
    req_pt_ok = pt; req_pmp_ok = pmp; req_rdata = rd;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [3:0] cause_for(input logic [1:0] kind);
    if (kind == 2'd0) return 4'd1;
    if (kind == 2'd2) return 4'd7;
    return 4'd5;
  endfunction

  task automatic access(input string tag, input logic [31:0] pa, input logic [1:0] kind,
                        input logic [1:0] imp, input logic pt, input logic pmp,
                        input logic exp_grant);
    issue(pa, kind, imp, pt, pmp, 32'h0);
    check({tag, " valid"}, {31'b0, chk_valid}, 32'd1);
    check({tag, " grant"}, {31'b0, chk_grant}, {31'b0, exp_grant});
    check({tag, " fault"}, {31'b0, chk_fault}, {31'b0, !exp_grant});
    check({tag, " cause"}, {28'b0, chk_cause}, exp_grant ? 32'd0 : {28'b0, cause_for(kind)});
  endtask

  function automatic logic [31:0] pg(input int p, input int off);
    return (32'(p) << 12) | 32'(off);
  endfunction

  task automatic t_reset;
    check("R13 reset mode", {31'b0, cur_mode}, 32'd0);
    check("R13 reset sdid", {30'b0, cur_sdid}, 32'd0);
    check("R13 reset valid", {31'b0, chk_valid}, 32'd0);
    // table empty but Bare: load of page 5 is granted (R7)
    access("R13 bare after reset", pg(5, 0), 2'd1, 2'd0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_setup;
    cfg_write(2'd1, 20'd1, 2'd3);
    cfg_write(2'd2, 20'h100, 2'd3);
    check("R8 mode set by machine", {31'b0, cur_mode}, 32'd1);
    tbl_write(2'd0, 6'd1, 2'b01, 2'd3);
    tbl_write(2'd0, 6'd2, 2'b11, 2'd3);
    tbl_write(2'd0, 6'd3, 2'b10, 2'd3);
  endtask

  task automatic t_perm;
    access("R1 load R page", pg(1, 8), 2'd1, 2'd0, 1'b1, 1'b1, 1'b1);
    access("R1 R5 store R page", pg(1, 8), 2'd2, 2'd0, 1'b1, 1'b1, 1'b0);
    access("R1 fetch R page", pg(1, 0), 2'd0, 2'd0, 1'b1, 1'b1, 1'b1);
    access("R1 R5 fetch W page", pg(3, 0), 2'd0, 2'd0, 1'b1, 1'b1, 1'b0);
    access("R1 R5 load W page", pg(3, 4), 2'd1, 2'd0, 1'b1, 1'b1, 1'b0);
    access("R1 store W page", pg(3, 4), 2'd2, 2'd0, 1'b1, 1'b1, 1'b1);
    access("R1 store RW page", pg(2, 4), 2'd2, 2'd0, 1'b1, 1'b1, 1'b1);
    access("R1 load empty page", pg(0, 4), 2'd1, 2'd0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_combine;
    access("R2 pt deny", pg(2, 0), 2'd1, 2'd0, 1'b0, 1'b1, 1'b0);
    access("R2 pmp deny", pg(2, 0), 2'd2, 2'd0, 1'b1, 1'b0, 1'b0);
    access("R2 both deny", pg(2, 0), 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    access("R2 all allow", pg(2, 0), 2'd1, 2'd0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_implicit;
    access("R3 AD update on R page", pg(1, 0), 2'd0, 2'd2, 1'b1, 1'b1, 1'b0);
    access("R3 walk read for store", pg(1, 0), 2'd2, 2'd1, 1'b1, 1'b1, 1'b1);
    access("R3 AD update for load on W page", pg(3, 0), 2'd1, 2'd2, 1'b1, 1'b1, 1'b1);
    access("R3 walk read on W page", pg(3, 0), 2'd2, 2'd1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_exempt;
    access("R4 load root page", pg(32'h100, 16), 2'd1, 2'd0, 1'b1, 1'b1, 1'b1);
    access("R4 store root page", pg(32'h100, 16), 2'd2, 2'd0, 1'b1, 1'b1, 1'b1);
    access("R4 page after root", pg(32'h101, 0), 2'd1, 2'd0, 1'b1, 1'b1, 1'b0);
    access("R4 exempt still needs pmp", pg(32'h100, 0), 2'd1, 2'd0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_oor;
    access("R11 page 64", pg(64, 0), 2'd1, 2'd0, 1'b1, 1'b1, 1'b0);
    access("R11 page 65 aliasing R page", pg(65, 0), 2'd1, 2'd0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_rdata;
    issue(pg(2, 12), 2'd1, 2'd0, 1'b1, 1'b1, 32'hA5C3_0F19);
    check("R6 granted data", chk_rdata, 32'hA5C3_0F19);
    issue(pg(0, 12), 2'd1, 2'd0, 1'b1, 1'b1, 32'hDEAD_BEEF);
    check("R6 faulted data", chk_rdata, 32'h0);
    issue(pg(2, 12), 2'd1, 2'd0, 1'b1, 1'b0, 32'h1234_5678);
    check("R6 pmp denied data", chk_rdata, 32'h0);
  endtask

  task automatic t_pa;
    issue(32'h0000_2ABC, 2'd1, 2'd0, 1'b1, 1'b1, 32'h0);
    check("R9 pa in range", chk_pa, 32'h0000_2ABC);
    issue(32'hFFFF_F123, 2'd2, 2'd0, 1'b1, 1'b1, 32'h0);
    check("R9 pa high faulted", chk_pa, 32'hFFFF_F123);
  endtask

  task automatic t_timing;
    issue(pg(1, 0), 2'd1, 2'd0, 1'b1, 1'b1, 32'h0);
    check("R10 pulse present", {31'b0, chk_valid}, 32'd1);
    @(negedge clk);
    check("R10 pulse ended", {31'b0, chk_valid}, 32'd0);
    check("R10 no grant when idle", {31'b0, chk_grant}, 32'd0);
    check("R10 no fault when idle", {31'b0, chk_fault}, 32'd0);
  endtask

  task automatic t_domain;
    cfg_write(2'd0, 20'd1, 2'd3);
    check("R12 sdid switched", {30'b0, cur_sdid}, 32'd1);
    access("R12 domain1 unprogrammed", pg(2, 0), 2'd1, 2'd0, 1'b1, 1'b1, 1'b0);
    tbl_write(2'd1, 6'd2, 2'b01, 2'd3);
    access("R12 domain1 read", pg(2, 0), 2'd1, 2'd0, 1'b1, 1'b1, 1'b1);
    access("R12 domain1 write", pg(2, 0), 2'd2, 2'd0, 1'b1, 1'b1, 1'b0);
    cfg_write(2'd0, 20'd0, 2'd3);
    access("R12 domain0 kept RW", pg(2, 0), 2'd2, 2'd0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_priv;
    cfg_write(2'd1, 20'd0, 2'd1);
    check("R8 mode kept", {31'b0, cur_mode}, 32'd1);
    cfg_write(2'd0, 20'd2, 2'd0);
    check("R8 sdid kept", {30'b0, cur_sdid}, 32'd0);
    cfg_write(2'd2, 20'd0, 2'd1);
    access("R8 root kept", pg(32'h100, 0), 2'd1, 2'd0, 1'b1, 1'b1, 1'b1);
    tbl_write(2'd0, 6'd0, 2'b11, 2'd1);
    access("R8 table kept", pg(0, 0), 2'd1, 2'd0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_bare;
    cfg_write(2'd1, 20'd0, 2'd3);
    access("R7 bare empty page", pg(0, 0), 2'd2, 2'd0, 1'b1, 1'b1, 1'b1);
    access("R7 bare out of range", pg(64, 0), 2'd0, 2'd0, 1'b1, 1'b1, 1'b1);
    access("R7 bare pt deny", pg(0, 0), 2'd1, 2'd0, 1'b0, 1'b1, 1'b0);
    access("R7 bare pmp deny", pg(0, 0), 2'd2, 2'd0, 1'b1, 1'b0, 1'b0);
    cfg_write(2'd1, 20'd1, 2'd3);
    access("R7 checked again", pg(0, 0), 2'd1, 2'd0, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_setup;
    t_perm;
    t_combine;
    t_implicit;
    t_exempt;
    t_oor;
    t_rdata;
    t_pa;
    t_timing;
    t_domain;
    t_priv;
    t_bare;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule